// File: doc/BRIEF.md
# Operand Effective Address Generator

This block turns the addressing-mode code and operand bytes of an 8-bit processor instruction into the 16-bit address that the execute stage reads or writes. It sits between instruction decode and data execution. The decoder captures the operand bytes together with the current X, Y and program counter values, and raises `start` for one cycle. The block then returns the effective address, or marks the operand as an immediate byte, with a one-cycle `done` pulse.

Some modes need only arithmetic: the direct zero page, absolute, indexed and relative forms. These complete one cycle after the start. The three indirect modes first fetch a little-endian pointer, low byte then high byte, through a byte-wide read port with one cycle of latency. The block applies the addressing rules itself. Zero-page sums stay inside page zero. X is added before the pointer fetch and Y after it. The relative offset is a signed byte.

Top module: `opnd_addr_unit`

## Requirements
- R1: While reset is asserted, and on the first cycles after it is released, `done`, `busy` and `rd_en` are all 0.
- R2: Mode codes: 0 implied, 1 immediate, 2 zero page, 3 zero page+X, 4 zero page+Y, 5 absolute, 6 absolute+X, 7 absolute+Y, 8 indirect, 9 pre-indexed indirect (X), 10 post-indexed indirect (Y), 11 relative; codes 12 to 15 behave as implied. Every mode except 8, 9 and 10 raises `done` on the cycle after the accepted start and issues no read. `is_imm` is 1 with `done` only for code 1. Implied gives `ea` = 0x0000.
- R3: The zero page modes give `ea` = {0x00, low operand}. In the indexed forms, the sum with X or Y wraps modulo 256, so 0xF0+0x20 gives 0x0010.
- R4: Absolute gives `ea` = {high, low}. The indexed forms add X or Y across the full 16 bits. For example, 0x1111+0x02 gives 0x1113, 0x12FF+0x01 gives 0x1300, and 0xFFFF+0x01 gives 0x0000.
- R5: Relative gives `ea` = pc plus the low operand sign-extended to 16 bits. For example, 0xC100 with 0x2D gives 0xC12D, 0xC100 with 0x80 gives 0xC080, and 0x0005 with 0xFE gives 0x0003.
- R6: Indirect reads the pointer low byte at {high, low} and the high byte at that address plus one, with a carry into the upper byte. `ea` is {second byte, first byte}.
- R7: Pre-indexed indirect reads at {0x00, (low+X) mod 256}, then at {0x00, (low+X+1) mod 256}. `ea` is the fetched pair.
- R8: Post-indexed indirect reads at {0x00, low}, then at {0x00, (low+1) mod 256}. `ea` is the fetched pair plus Y, with a carry across all 16 bits.
- R9: In a pointer mode, `rd_en` is high for exactly the two cycles that follow the accepted start, low-byte address first. `rd_data` is taken one cycle after each read. `busy` is high from the cycle after the start until `done`, which rises four cycles after the start edge.
- R10: A `start` while `busy` is high is ignored. The operation in flight returns its own result and no extra `done` appears.
- R11: Each accepted start gives exactly one `done` pulse. Starts held high on consecutive idle cycles are each accepted, so back-to-back direct modes give `done` on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin address generation with the inputs presented this cycle |
| mode | input | 4 | Addressing-mode code (see R2) |
| opnd_lo | input | 8 | First operand byte (zero page address, low address byte or offset) |
| opnd_hi | input | 8 | Second operand byte (high address byte) |
| idx_x | input | 8 | X index value |
| idx_y | input | 8 | Y index value |
| pc | input | 16 | Program counter used by relative mode |
| rd_en | output | 1 | Pointer byte read request |
| rd_addr | output | 16 | Pointer byte read address |
| rd_data | input | 8 | Read data, valid the cycle after `rd_en` |
| busy | output | 1 | Pointer fetch in progress; starts are ignored |
| done | output | 1 | One-cycle pulse: `ea` and `is_imm` are valid |
| ea | output | 16 | Effective address |
| is_imm | output | 1 | Operand is the immediate byte itself |

## Verification
The hardest cases to reach are the pointer fetches at the edge of page zero. A pre-indexed sum or a post-indexed base of 0xFF must take its high byte from address 0x0000, not 0x0100. A post-indexed Y must also carry out of the fetched low byte. The stimulus reaches these cases by choosing operand and index values that land the pointer on 0xFF. It then checks every read address in order, alongside the final address. Ignored starts are driven by holding `start` high with a different mode through the busy window of an indirect fetch.

// File: rtl/opnd_addr_pkg.sv
package opnd_addr_pkg;

  parameter int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    AM_IMPL    = 4'd0,
    AM_IMM     = 4'd1,
    AM_ZP      = 4'd2,
    AM_ZPX     = 4'd3,
    AM_ZPY     = 4'd4,
    AM_ABS     = 4'd5,
    AM_ABX     = 4'd6,
    AM_ABY     = 4'd7,
    AM_IND     = 4'd8,
    AM_IDX_IND = 4'd9,
    AM_IND_IDX = 4'd10,
    AM_REL     = 4'd11
  } amode_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_LO   = 2'd1,
    SQ_HI   = 2'd2,
    SQ_JOIN = 2'd3
  } seq_state_e;

endpackage

// File: rtl/oa_rst_sync.sv
module oa_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/oa_index_add.sv
// Combinational decode of the mode code into either a finished address
// (direct modes) or a pointer location plus post-fetch instructions.
module oa_index_add
  import opnd_addr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [MODE_W-1:0]   mode,
  input  logic [DATA_W-1:0]   opnd_lo,
  input  logic [DATA_W-1:0]   opnd_hi,
  input  logic [DATA_W-1:0]   idx_x,
  input  logic [DATA_W-1:0]   idx_y,
  input  logic [2*DATA_W-1:0] pc,
  output logic [2*DATA_W-1:0] dir_ea,
  output logic                dir_imm,
  output logic                need_ptr,
  output logic [2*DATA_W-1:0] ptr_base,
  output logic                ptr_in_zp,
  output logic                ptr_post_y
);

  localparam int ADDR_W = 2 * DATA_W;

  logic [DATA_W-1:0] zp_plus_x;
  logic [DATA_W-1:0] zp_plus_y;
  logic [ADDR_W-1:0] abs_base;
  logic [ADDR_W-1:0] rel_off;

  always_comb begin
    zp_plus_x = opnd_lo + idx_x;
    zp_plus_y = opnd_lo + idx_y;
    abs_base  = {opnd_hi, opnd_lo};
    rel_off   = {{DATA_W{opnd_lo[DATA_W-1]}}, opnd_lo};
  end

  always_comb begin
    dir_ea     = '0;
    dir_imm    = 1'b0;
    need_ptr   = 1'b0;
    ptr_base   = '0;
    ptr_in_zp  = 1'b0;
    ptr_post_y = 1'b0;
    case (amode_e'(mode))
      AM_IMM:     dir_imm = 1'b1;
      AM_ZP:      dir_ea  = {{DATA_W{1'b0}}, opnd_lo};
      AM_ZPX:     dir_ea  = {{DATA_W{1'b0}}, zp_plus_x};
      AM_ZPY:     dir_ea  = {{DATA_W{1'b0}}, zp_plus_y};
      AM_ABS:     dir_ea  = abs_base;
      AM_ABX:     dir_ea  = abs_base + {{DATA_W{1'b0}}, idx_x};
      AM_ABY:     dir_ea  = abs_base + {{DATA_W{1'b0}}, idx_y};
      AM_REL:     dir_ea  = pc + rel_off;
      AM_IND: begin
        need_ptr = 1'b1;
        ptr_base = abs_base;
      end
      AM_IDX_IND: begin
        need_ptr  = 1'b1;
        ptr_in_zp = 1'b1;
        ptr_base  = {{DATA_W{1'b0}}, zp_plus_x};
      end
      AM_IND_IDX: begin
        need_ptr   = 1'b1;
        ptr_in_zp  = 1'b1;
        ptr_post_y = 1'b1;
        ptr_base   = {{DATA_W{1'b0}}, opnd_lo};
      end
      default: dir_ea = '0;
    endcase
  end

endmodule

// File: rtl/oa_ptr_seq.sv
// Two-byte pointer fetch sequencer: low byte, high byte, then join.
module oa_ptr_seq
  import opnd_addr_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter bit IND_PAGE_WRAP = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                launch,
  input  logic [2*DATA_W-1:0] base,
  input  logic                in_zp,
  input  logic                post_y,
  input  logic [DATA_W-1:0]   idx_y,
  input  logic [DATA_W-1:0]   rd_data,
  output logic                rd_en,
  output logic [2*DATA_W-1:0] rd_addr,
  output logic                busy,
  output logic                fin_vld,
  output logic [2*DATA_W-1:0] fin_ea
);

  localparam int ADDR_W = 2 * DATA_W;

  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] base_q;
  logic              zp_q;
  logic              post_q;
  logic [DATA_W-1:0] y_q;
  logic [DATA_W-1:0] lo_q;
  logic [ADDR_W-1:0] hi_addr;
  logic [DATA_W-1:0] base_lo_inc;
  logic              lo_en;

  assign base_lo_inc = base_q[DATA_W-1:0] + 1'b1;

  generate
    if (IND_PAGE_WRAP) begin : g_wrap
      assign hi_addr = zp_q ? {{DATA_W{1'b0}}, base_lo_inc}
                            : {base_q[ADDR_W-1:DATA_W], base_lo_inc};
    end else begin : g_carry
      assign hi_addr = zp_q ? {{DATA_W{1'b0}}, base_lo_inc}
                            : base_q + 1'b1;
    end
  endgenerate

  always_comb begin
    state_d = state_q;
    case (state_q)
      SQ_IDLE: if (launch) state_d = SQ_LO;
      SQ_LO:   state_d = SQ_HI;
      SQ_HI:   state_d = SQ_JOIN;
      SQ_JOIN: state_d = SQ_IDLE;
      default: state_d = SQ_IDLE;
    endcase
  end

  assign lo_en   = (state_q == SQ_HI);
  assign rd_en   = (state_q == SQ_LO) || (state_q == SQ_HI);
  assign rd_addr = (state_q == SQ_HI) ? hi_addr : base_q;
  assign busy    = (state_q != SQ_IDLE);
  assign fin_vld = (state_q == SQ_JOIN);
  assign fin_ea  = {rd_data, lo_q} +
                   (post_q ? {{DATA_W{1'b0}}, y_q} : {ADDR_W{1'b0}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      base_q  <= '0;
      zp_q    <= 1'b0;
      post_q  <= 1'b0;
      y_q     <= '0;
      lo_q    <= '0;
    end else begin
      state_q <= state_d;
      if (launch) begin
        base_q <= base;
        zp_q   <= in_zp;
        post_q <= post_y;
        y_q    <= idx_y;
      end
      if (lo_en) lo_q <= rd_data;
    end
  end

endmodule

// File: rtl/opnd_addr_unit.sv
module opnd_addr_unit
  import opnd_addr_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter bit IND_PAGE_WRAP = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [MODE_W-1:0]   mode,
  input  logic [DATA_W-1:0]   opnd_lo,
  input  logic [DATA_W-1:0]   opnd_hi,
  input  logic [DATA_W-1:0]   idx_x,
  input  logic [DATA_W-1:0]   idx_y,
  input  logic [2*DATA_W-1:0] pc,
  output logic                rd_en,
  output logic [2*DATA_W-1:0] rd_addr,
  input  logic [DATA_W-1:0]   rd_data,
  output logic                busy,
  output logic                done,
  output logic [2*DATA_W-1:0] ea,
  output logic                is_imm
);

  localparam int ADDR_W = 2 * DATA_W;

  logic              rst_sync_n;
  logic              accept;
  logic [ADDR_W-1:0] dir_ea;
  logic              dir_imm;
  logic              need_ptr;
  logic [ADDR_W-1:0] ptr_base;
  logic              ptr_in_zp;
  logic              ptr_post_y;
  logic              fin_vld;
  logic [ADDR_W-1:0] fin_ea;
  logic              done_d, done_q;
  logic [ADDR_W-1:0] ea_d, ea_q;
  logic              imm_d, imm_q;
  logic              out_en;

  oa_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  oa_index_add #(.DATA_W(DATA_W)) u_calc (
    .mode       (mode),
    .opnd_lo    (opnd_lo),
    .opnd_hi    (opnd_hi),
    .idx_x      (idx_x),
    .idx_y      (idx_y),
    .pc         (pc),
    .dir_ea     (dir_ea),
    .dir_imm    (dir_imm),
    .need_ptr   (need_ptr),
    .ptr_base   (ptr_base),
    .ptr_in_zp  (ptr_in_zp),
    .ptr_post_y (ptr_post_y)
  );

  assign accept = start && !busy;

  oa_ptr_seq #(.DATA_W(DATA_W), .IND_PAGE_WRAP(IND_PAGE_WRAP)) u_seq (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .launch  (accept && need_ptr),
    .base    (ptr_base),
    .in_zp   (ptr_in_zp),
    .post_y  (ptr_post_y),
    .idx_y   (idx_y),
    .rd_data (rd_data),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .busy    (busy),
    .fin_vld (fin_vld),
    .fin_ea  (fin_ea)
  );

  always_comb begin
    done_d = (accept && !need_ptr) || fin_vld;
    ea_d   = fin_vld ? fin_ea : dir_ea;
    imm_d  = accept && !need_ptr && dir_imm;
    out_en = done_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      done_q <= 1'b0;
      ea_q   <= '0;
      imm_q  <= 1'b0;
    end else begin
      done_q <= done_d;
      if (out_en) begin
        ea_q  <= ea_d;
        imm_q <= imm_d;
      end
    end
  end

  assign done   = done_q;
  assign ea     = ea_q;
  assign is_imm = imm_q;

endmodule

// File: rtl/opnd_addr_unit_chk.sv
module opnd_addr_unit_chk
  import opnd_addr_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [MODE_W-1:0] mode,
  input logic              busy,
  input logic              done,
  input logic              is_imm,
  input logic [15:0]       ea,
  input logic              rd_en,
  input logic [15:0]       rd_addr
);

  logic [MODE_W-1:0] ck_mode;
  logic              acc;
  logic              acc_ptr;
  logic              acc_zp;

  assign acc     = start && !busy;
  assign acc_ptr = acc && (mode == AM_IND || mode == AM_IDX_IND || mode == AM_IND_IDX);
  assign acc_zp  = acc && (mode == AM_ZP || mode == AM_ZPX || mode == AM_ZPY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ck_mode <= '0;
    else if (acc) ck_mode <= mode;
  end

  a_r9_read_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> busy);

  a_r2_direct_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !acc_ptr) |=> (done && !busy && !rd_en));

  a_r9_ptr_reads_first: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ptr |=> (busy && rd_en && !done));

  a_r9_two_reads: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_en) |=> rd_en);

  a_r3_zp_page: assert property (@(posedge clk) disable iff (!rst_n)
    acc_zp |=> (ea[15:8] == 8'h00));

  a_r7_zp_pointer_page: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (ck_mode == AM_IDX_IND || ck_mode == AM_IND_IDX)) |-> (rd_addr[15:8] == 8'h00));

  a_r6_hi_after_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && $past(rd_en)) |-> (rd_addr[7:0] == $past(rd_addr[7:0]) + 8'd1));

  a_r2_imm_flag: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (is_imm == (ck_mode == AM_IMM)));

endmodule

bind opnd_addr_unit opnd_addr_unit_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .start   (start),
  .mode    (mode),
  .busy    (busy),
  .done    (done),
  .is_imm  (is_imm),
  .ea      (ea),
  .rd_en   (rd_en),
  .rd_addr (rd_addr)
);

// File: tb/opnd_addr_unit_bench.sv
module opnd_addr_unit_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [3:0]  mode;
  logic [7:0]  opnd_lo, opnd_hi, idx_x, idx_y;
  logic [15:0] pc;
  logic        rd_en;
  logic [15:0] rd_addr;
  logic [7:0]  rd_data;
  logic        busy, done, is_imm;
  logic [15:0] ea;

  int n_chk;
  int n_bad;
  int cyc;
  bit mon_on;

  typedef struct {
    logic [15:0] ea;
    logic        imm;
    int          due;
    string       tag;
  } res_t;

  typedef struct {
    logic [15:0] a;
    string       tag;
  } rd_t;

  res_t res_q[$];
  rd_t  rd_q[$];

  opnd_addr_unit u_opnd_addr_unit (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .mode    (mode),
    .opnd_lo (opnd_lo),
    .opnd_hi (opnd_hi),
    .idx_x   (idx_x),
    .idx_y   (idx_y),
    .pc      (pc),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .busy    (busy),
    .done    (done),
    .ea      (ea),
    .is_imm  (is_imm)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] mbyte(input logic [15:0] a);
    return (a[7:0] * 8'd7) ^ (a[15:8] * 8'd13) ^ 8'h3C;
  endfunction

  always @(posedge clk) if (rd_en) rd_data <= mbyte(rd_addr);

  // monitor: compares reads and results against the scoreboard
  always @(negedge clk) begin
    if (mon_on) begin
      if (rd_en) begin
        n_chk++;
        if (rd_q.size() == 0) begin
          n_bad++;
          $display("FAIL R2 unexpected read addr=%h expected none", rd_addr);
        end else begin
          rd_t r;
          r = rd_q.pop_front();
          if (rd_addr !== r.a) begin
            n_bad++;
            $display("FAIL %s read addr=%h expected %h", r.tag, rd_addr, r.a);
          end
        end
      end
      if (done) begin
        n_chk++;
        if (res_q.size() == 0) begin
          n_bad++;
          $display("FAIL R11 unexpected done ea=%h expected no done", ea);
        end else begin
          res_t e;
          e = res_q.pop_front();
          if (ea !== e.ea || is_imm !== e.imm || cyc != e.due) begin
            n_bad++;
            $display("FAIL %s ea=%h imm=%b cyc=%0d expected ea=%h imm=%b cyc=%0d",
                     e.tag, ea, is_imm, cyc, e.ea, e.imm, e.due);
          end
        end
      end
    end
  end

  // driver: computes expectation from the requirements and pushes it
  task automatic issue(input logic [3:0] m, input logic [7:0] lo, input logic [7:0] hi,
                       input logic [7:0] x, input logic [7:0] y, input logic [15:0] p,
                       input string tag, input bit wait_done);
    res_t e;
    rd_t  r0, r1;
    logic [15:0] pa, pb;
    logic [7:0]  z;
    e.ea = 16'h0000; e.imm = 1'b0; e.due = cyc + 1; e.tag = tag;
    case (m)
      4'd1:  e.imm = 1'b1;
      4'd2:  e.ea = {8'h00, lo};
      4'd3:  begin z = lo + x; e.ea = {8'h00, z}; end
      4'd4:  begin z = lo + y; e.ea = {8'h00, z}; end
      4'd5:  e.ea = {hi, lo};
      4'd6:  e.ea = {hi, lo} + {8'h00, x};
      4'd7:  e.ea = {hi, lo} + {8'h00, y};
      4'd11: e.ea = p + {{8{lo[7]}}, lo};
      4'd8, 4'd9, 4'd10: begin
        if (m == 4'd8) begin
          pa = {hi, lo}; pb = pa + 16'd1;
        end else begin
          z  = (m == 4'd9) ? lo + x : lo;
          pa = {8'h00, z}; z = z + 8'd1; pb = {8'h00, z};
        end
        e.ea = {mbyte(pb), mbyte(pa)};
        if (m == 4'd10) e.ea = e.ea + {8'h00, y};
        e.due = cyc + 4;
        r0.a = pa; r0.tag = tag; r1.a = pb; r1.tag = tag;
        rd_q.push_back(r0);
        rd_q.push_back(r1);
      end
      default: e.ea = 16'h0000;
    endcase
    res_q.push_back(e);
    mode = m; opnd_lo = lo; opnd_hi = hi; idx_x = x; idx_y = y; pc = p;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (wait_done) begin
      while (res_q.size() != 0 || rd_q.size() != 0) @(negedge clk);
    end
  endtask

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired: pending results=%0d expected 0", res_q.size());
    report();
  end

  initial begin
    cyc = 0; n_chk = 0; n_bad = 0; mon_on = 1'b0;
    rst_n = 1'b0; start = 1'b0; mode = '0; opnd_lo = '0; opnd_hi = '0;
    idx_x = '0; idx_y = '0; pc = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    n_chk++;
    if (done !== 1'b0 || busy !== 1'b0 || rd_en !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 reset state done=%b busy=%b rd_en=%b expected 0 0 0", done, busy, rd_en);
    end
    repeat (3) @(negedge clk);
    mon_on = 1'b1;

    issue(4'd0,  8'h77, 8'h88, 8'h01, 8'h02, 16'h1234, "R2 implied", 1);
    issue(4'd1,  8'h22, 8'h00, 8'h00, 8'h00, 16'h0600, "R2 immediate", 1);
    issue(4'd13, 8'h55, 8'h66, 8'h00, 8'h00, 16'h0000, "R2 unused code", 1);
    issue(4'd2,  8'h42, 8'h99, 8'h10, 8'h20, 16'h0000, "R3 zero page", 1);
    issue(4'd3,  8'hF0, 8'h12, 8'h20, 8'h00, 16'h0000, "R3 zp+x wrap", 1);
    issue(4'd4,  8'h14, 8'h00, 8'h00, 8'h05, 16'h0000, "R3 zp+y", 1);
    issue(4'd5,  8'h10, 8'hD0, 8'h03, 8'h04, 16'h0000, "R4 absolute", 1);
    issue(4'd6,  8'h11, 8'h11, 8'h02, 8'h00, 16'h0000, "R4 abs+x", 1);
    issue(4'd7,  8'hFF, 8'h12, 8'h00, 8'h01, 16'h0000, "R4 abs+y carry", 1);
    issue(4'd6,  8'hFF, 8'hFF, 8'h01, 8'h00, 16'h0000, "R4 abs+x top wrap", 1);
    issue(4'd11, 8'h2D, 8'h00, 8'h00, 8'h00, 16'hC100, "R5 forward", 1);
    issue(4'd11, 8'h80, 8'h00, 8'h00, 8'h00, 16'hC100, "R5 backward", 1);
    issue(4'd11, 8'hFE, 8'h00, 8'h00, 8'h00, 16'h0005, "R5 small back", 1);
    issue(4'd8,  8'h55, 8'h2E, 8'h00, 8'h00, 16'h0000, "R6 R9 indirect", 1);
    issue(4'd8,  8'hFF, 8'h10, 8'h00, 8'h00, 16'h0000, "R6 indirect carry", 1);
    issue(4'd9,  8'h13, 8'h77, 8'h05, 8'h00, 16'h0000, "R7 R9 pre-indexed", 1);
    issue(4'd9,  8'hFE, 8'h00, 8'h01, 8'h00, 16'h0000, "R7 pre-indexed page wrap", 1);
    issue(4'd10, 8'h25, 8'h00, 8'h00, 8'h10, 16'h0000, "R8 R9 post-indexed", 1);
    issue(4'd10, 8'hFF, 8'h00, 8'h33, 8'hF0, 16'h0000, "R8 post-indexed wrap carry", 1);

    // R10: start held through the busy window with a different mode
    issue(4'd10, 8'h40, 8'h00, 8'h00, 8'h08, 16'h0000, "R10 in-flight result", 0);
    mode = 4'd2; opnd_lo = 8'h99; start = 1'b1;
    @(negedge clk);
    @(negedge clk);
    start = 1'b0;
    while (res_q.size() != 0 || rd_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    n_chk++;
    if (done !== 1'b0 || busy !== 1'b0) begin
      n_bad++;
      $display("FAIL R10 after ignored starts done=%b busy=%b expected 0 0", done, busy);
    end

    // R11: back-to-back direct starts
    issue(4'd5, 8'h01, 8'h20, 8'h00, 8'h00, 16'h0000, "R11 back-to-back first", 0);
    issue(4'd3, 8'h80, 8'h00, 8'h90, 8'h00, 16'h0000, "R11 back-to-back second", 1);
    repeat (2) @(negedge clk);
    n_chk++;
    if (res_q.size() != 0 || rd_q.size() != 0) begin
      n_bad++;
      $display("FAIL R11 pending results=%0d reads=%0d expected 0 0", res_q.size(), rd_q.size());
    end
    report();
  end

endmodule